// File: doc/BRIEF.md
# Region-Based Compact Routing Unit

This block stands in for a full per-destination routing table inside a mesh router. It holds a small, fixed number of programmable region entries (eight by default). Each entry describes a rectangle of destination coordinates with inclusive lower and upper bounds in X and Y, a mask of the arrival ports the entry applies to, a mask of the output ports it permits, and an enable bit. Software or a boot sequencer loads the entries through a simple write port that carries an entry index, a field select and a data word.

On every lookup the destination and arrival port are compared against all entries at once. The permitted-output masks of every matching entry are ORed into one set of routing options, which a later selection stage chooses from. A destination equal to this router's own coordinates always returns the ejection port alone, whatever the entries say. When no entry matches, the unit raises a no-route flag and returns an empty option set. The result appears one clock after the lookup is presented.

The result stage is a four-state machine. ST_IDLE means no lookup was presented in the previous cycle. ST_LOCAL means the last lookup addressed this node. ST_HIT means at least one entry matched. ST_MISS means no entry matched. Each cycle the next state follows the current lookup alone: no lookup goes to ST_IDLE, a local destination goes to ST_LOCAL, any match goes to ST_HIT, and otherwise ST_MISS. This holds from any state.

Top module: `region_router`

## Requirements
- R1: After reset the result is idle (res_valid, res_noroute and res_opts all zero) and every entry is disabled, so a lookup to a non-local destination returns no route.
- R2: An entry matches only when lo_x <= dst_x <= hi_x and lo_y <= dst_y <= hi_y, both bounds inclusive.
- R3: An entry matches only when bit lk_in_port of its arrival mask is set.
- R4: An entry whose enable bit is clear never matches, whatever its other fields hold.
- R5: res_opts is the bitwise OR of the permitted-output masks of all matching entries.
- R6: A lookup whose destination equals (LOCAL_X, LOCAL_Y) returns res_opts with only bit EJECT_PORT set and res_noroute low, regardless of the entries.
- R7: A non-local lookup that matches no entry returns res_noroute high and res_opts zero.
- R8: res_valid is high exactly in the cycle after lk_valid was high. When res_valid is low, res_opts and res_noroute are zero.
- R9: A write with cfg_we high stores cfg_data into the entry cfg_idx. The field codes are 0 lo_x, 1 hi_x, 2 lo_y, 3 hi_y, 4 arrival mask, 5 output mask, and 6 enable (data bit 0). Code 7 changes nothing. A write is seen by lookups from the next cycle on, and a lookup in the same cycle uses the old contents.
- R10: An arrival port number of NPORT or above matches no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Entry index to write |
| cfg_fld | input | 3 | Field select code |
| cfg_data | input | DW | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_dst_x | input | CW | Destination X coordinate |
| lk_dst_y | input | CW | Destination Y coordinate |
| lk_in_port | input | PW | Arrival port number |
| res_valid | output | 1 | Lookup result valid |
| res_opts | output | NPORT | Permitted output ports |
| res_noroute | output | 1 | No entry matched |

## Verification
A corrupted bound, mask or enable bit inside one entry shows up as a wrong res_opts or a wrong res_noroute on the first lookup that touches that entry. The result appears one cycle after the request, so the mismatch is visible then. For this reason the bench sweeps destinations across and just outside every programmed rectangle and tries every arrival port, including out-of-range ones. A wrong result-state transition shows immediately in res_valid or res_noroute. A write that lands in the wrong field or entry, or that takes effect a cycle early, is caught by lookups issued in the same cycle as the write and in the cycle after it.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    typedef enum logic [2:0] {
        FLD_XLO  = 3'd0,
        FLD_XHI  = 3'd1,
        FLD_YLO  = 3'd2,
        FLD_YHI  = 3'd3,
        FLD_INM  = 3'd4,
        FLD_OUTM = 3'd5,
        FLD_EN   = 3'd6,
        FLD_RSV  = 3'd7
    } cfg_fld_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOCAL = 2'd1,
        ST_HIT   = 2'd2,
        ST_MISS  = 2'd3
    } res_state_e;

endpackage

// File: rtl/rgn_entry.sv
module rgn_entry
    import rgn_pkg::*;
#(
    parameter int CW    = 4,
    parameter int NPORT = 5,
    parameter int PW    = 3,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_fld,
    input  logic [DW-1:0]    wr_data,
    input  logic [CW-1:0]    dst_x,
    input  logic [CW-1:0]    dst_y,
    input  logic [PW-1:0]    in_port,
    output logic             match,
    output logic [NPORT-1:0] grant
);

    logic [CW-1:0]    lo_x_q, hi_x_q, lo_y_q, hi_y_q;
    logic [NPORT-1:0] in_mask_q, out_mask_q;
    logic             en_q;
    logic             port_ok;
    logic             in_range;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_x_q     <= '0;
            hi_x_q     <= '0;
            lo_y_q     <= '0;
            hi_y_q     <= '0;
            in_mask_q  <= '0;
            out_mask_q <= '0;
            en_q       <= 1'b0;
        end else if (wr_en) begin
            unique case (cfg_fld_e'(wr_fld))
                FLD_XLO:  lo_x_q     <= wr_data[CW-1:0];
                FLD_XHI:  hi_x_q     <= wr_data[CW-1:0];
                FLD_YLO:  lo_y_q     <= wr_data[CW-1:0];
                FLD_YHI:  hi_y_q     <= wr_data[CW-1:0];
                FLD_INM:  in_mask_q  <= wr_data[NPORT-1:0];
                FLD_OUTM: out_mask_q <= wr_data[NPORT-1:0];
                FLD_EN:   en_q       <= wr_data[0];
                FLD_RSV:  ;
                default:  ;
            endcase
        end
    end

    always_comb begin
        port_ok = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (in_port == PW'(p) && in_mask_q[p]) begin
                port_ok = 1'b1;
            end
        end
    end

    assign in_range = (dst_x >= lo_x_q) && (dst_x <= hi_x_q) &&
                      (dst_y >= lo_y_q) && (dst_y <= hi_y_q);
    assign match    = en_q && port_ok && in_range;
    assign grant    = match ? out_mask_q : '0;

    // R10: an out-of-range arrival port never yields a match
    p_port_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (32'(in_port) < NPORT));

    // R4: a disabled entry grants nothing
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (grant == '0));

endmodule

// File: rtl/rgn_merge.sv
module rgn_merge #(
    parameter int NREG  = 8,
    parameter int NPORT = 5
) (
    input  logic [NREG-1:0]            match_vec,
    input  logic [NREG*NPORT-1:0]      grant_flat,
    output logic                       any_hit,
    output logic [NPORT-1:0]           opts
);

    logic [NPORT-1:0] acc [NREG+1];

    assign acc[0] = '0;

    for (genvar r = 0; r < NREG; r++) begin : g_or
        assign acc[r+1] = acc[r] | grant_flat[r*NPORT +: NPORT];
    end

    assign opts    = acc[NREG];
    assign any_hit = |match_vec;

endmodule

// File: rtl/region_router.sv
module region_router
    import rgn_pkg::*;
#(
    parameter int NREG       = 8,
    parameter int CW         = 4,
    parameter int NPORT      = 5,
    parameter int DW         = 8,
    parameter int LOCAL_X    = 2,
    parameter int LOCAL_Y    = 3,
    parameter int EJECT_PORT = 0,
    localparam int IDXW      = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int PW        = $clog2(NPORT) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDXW-1:0]  cfg_idx,
    input  logic [2:0]       cfg_fld,
    input  logic [DW-1:0]    cfg_data,
    input  logic             lk_valid,
    input  logic [CW-1:0]    lk_dst_x,
    input  logic [CW-1:0]    lk_dst_y,
    input  logic [PW-1:0]    lk_in_port,
    output logic             res_valid,
    output logic [NPORT-1:0] res_opts,
    output logic             res_noroute
);

    localparam logic [NPORT-1:0] EJECT_ONEHOT = NPORT'(1) << EJECT_PORT;

    logic [NREG-1:0]       match_vec;
    logic [NREG*NPORT-1:0] grant_flat;
    logic                  any_hit;
    logic [NPORT-1:0]      merged;
    logic                  is_local;

    res_state_e            state_q, state_d;
    logic [NPORT-1:0]      opts_q, opts_d;

    for (genvar r = 0; r < NREG; r++) begin : g_entry
        rgn_entry #(
            .CW(CW), .NPORT(NPORT), .PW(PW), .DW(DW)
        ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_idx == IDXW'(r))),
            .wr_fld  (cfg_fld),
            .wr_data (cfg_data),
            .dst_x   (lk_dst_x),
            .dst_y   (lk_dst_y),
            .in_port (lk_in_port),
            .match   (match_vec[r]),
            .grant   (grant_flat[r*NPORT +: NPORT])
        );
    end

    rgn_merge #(.NREG(NREG), .NPORT(NPORT)) u_merge (
        .match_vec  (match_vec),
        .grant_flat (grant_flat),
        .any_hit    (any_hit),
        .opts       (merged)
    );

    assign is_local = (lk_dst_x == CW'(LOCAL_X)) && (lk_dst_y == CW'(LOCAL_Y));

    // next-state: depends only on the present lookup
    always_comb begin
        state_d = ST_IDLE;
        opts_d  = '0;
        if (lk_valid) begin
            if (is_local) begin
                state_d = ST_LOCAL;
            end else if (any_hit) begin
                state_d = ST_HIT;
                opts_d  = merged;
            end else begin
                state_d = ST_MISS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            opts_q  <= '0;
        end else begin
            state_q <= state_d;
            opts_q  <= opts_d;
        end
    end

    always_comb begin
        res_valid   = 1'b0;
        res_opts    = '0;
        res_noroute = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOCAL: begin
                res_valid = 1'b1;
                res_opts  = EJECT_ONEHOT;
            end
            ST_HIT: begin
                res_valid = 1'b1;
                res_opts  = opts_q;
            end
            ST_MISS: begin
                res_valid   = 1'b1;
                res_noroute = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: result follows the request by one cycle
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_opts == '0 && !res_noroute));

    // R6: local destination gives ejection only
    p_local_eject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && is_local) |=> (res_opts == EJECT_ONEHOT && !res_noroute));

    // R7: a no-route result carries no options
    p_noroute_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_noroute |-> (res_opts == '0));

    // R5: a hit reports the merged options of the entries matched
    p_hit_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !is_local && any_hit) |=> (res_opts == $past(merged) && !res_noroute));

endmodule

// File: tb/region_router_tb.sv
module region_router_tb;

    localparam int NREG = 8, CW = 4, NPORT = 5, DW = 8;
    localparam int LX = 2, LY = 3, EJ = 0;
    localparam int IDXW = 3, PW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IDXW-1:0]  cfg_idx = '0;
    logic [2:0]       cfg_fld = '0;
    logic [DW-1:0]    cfg_data = '0;
    logic             lk_valid = 1'b0;
    logic [CW-1:0]    lk_dst_x = '0;
    logic [CW-1:0]    lk_dst_y = '0;
    logic [PW-1:0]    lk_in_port = '0;
    logic             res_valid;
    logic [NPORT-1:0] res_opts;
    logic             res_noroute;

    always #5 clk = ~clk;

    region_router #(
        .NREG(NREG), .CW(CW), .NPORT(NPORT), .DW(DW),
        .LOCAL_X(LX), .LOCAL_Y(LY), .EJECT_PORT(EJ)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_fld(cfg_fld), .cfg_data(cfg_data), .lk_valid(lk_valid),
        .lk_dst_x(lk_dst_x), .lk_dst_y(lk_dst_y), .lk_in_port(lk_in_port),
        .res_valid(res_valid), .res_opts(res_opts), .res_noroute(res_noroute)
    );

    // behavioural reference
    int m_lox[NREG], m_hix[NREG], m_loy[NREG], m_hiy[NREG];
    int m_inm[NREG], m_outm[NREG], m_en[NREG];
    int exp_valid, exp_opts, exp_nr;
    string exp_req;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic compare();
        checks++;
        if (int'(res_valid) != exp_valid || int'(res_opts) != exp_opts ||
            int'(res_noroute) != exp_nr) begin
            fails++;
            $display("FAIL %s: got valid=%0d opts=%b noroute=%0d, expected valid=%0d opts=%b noroute=%0d",
                     exp_req, res_valid, res_opts, res_noroute,
                     exp_valid, exp_opts[NPORT-1:0], exp_nr);
        end
    endtask

    // one clock: check previous result, drive new inputs, predict
    task automatic step(input bit we, input int idx, input int fld, input int data,
                        input bit lv, input int x, input int y, input int port,
                        input string req);
        @(negedge clk);
        compare();
        cfg_we = we; cfg_idx = IDXW'(idx); cfg_fld = 3'(fld); cfg_data = DW'(data);
        lk_valid = lv; lk_dst_x = CW'(x); lk_dst_y = CW'(y); lk_in_port = PW'(port);
        exp_req = req;
        exp_valid = lv; exp_opts = 0; exp_nr = 0;
        if (lv) begin
            if (x == LX && y == LY) begin
                exp_opts = 1 << EJ;
            end else begin
                bit hit = 1'b0;
                for (int r = 0; r < NREG; r++) begin
                    if (m_en[r] != 0 && port < NPORT && ((m_inm[r] >> port) & 1) != 0 &&
                        x >= m_lox[r] && x <= m_hix[r] && y >= m_loy[r] && y <= m_hiy[r]) begin
                        hit = 1'b1;
                        exp_opts = exp_opts | m_outm[r];
                    end
                end
                if (!hit) exp_nr = 1;
            end
        end
        if (we) begin
            case (fld)
                0: m_lox[idx]  = data & 15;
                1: m_hix[idx]  = data & 15;
                2: m_loy[idx]  = data & 15;
                3: m_hiy[idx]  = data & 15;
                4: m_inm[idx]  = data & 31;
                5: m_outm[idx] = data & 31;
                6: m_en[idx]   = data & 1;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input int idx, input int fld, input int data, input string req);
        step(1'b1, idx, fld, data, 1'b0, 0, 0, 0, req);
    endtask

    task automatic lk(input int x, input int y, input int port, input string req);
        step(1'b0, 0, 0, 0, 1'b1, x, y, port, req);
    endtask

    task automatic region(input int idx, input int lx, input int hx, input int ly,
                          input int hy, input int im, input int om);
        wr(idx, 0, lx, "R9"); wr(idx, 1, hx, "R9");
        wr(idx, 2, ly, "R9"); wr(idx, 3, hy, "R9");
        wr(idx, 4, im, "R9"); wr(idx, 5, om, "R9");
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) begin
            m_lox[r] = 0; m_hix[r] = 0; m_loy[r] = 0; m_hiy[r] = 0;
            m_inm[r] = 0; m_outm[r] = 0; m_en[r] = 0;
        end
        exp_valid = 0; exp_opts = 0; exp_nr = 0; exp_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, entries disabled
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "R1");
        lk(5, 5, 1, "R1");
        lk(0, 0, 0, "R1");
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "R8");

        // entry 0: x 4..6, y 1..3, arrival port 1, output port 2
        region(0, 4, 6, 1, 3, 5'b00010, 5'b00100);
        // R9: enable write and same-cycle lookup sees old contents
        step(1'b1, 0, 6, 1, 1'b1, 5, 2, 1, "R9");
        lk(5, 2, 1, "R9");
        // R2: inclusive bounds
        lk(4, 1, 1, "R2");
        lk(6, 3, 1, "R2");
        lk(7, 3, 1, "R2");
        lk(3, 2, 1, "R2");
        lk(4, 0, 1, "R2");
        lk(6, 4, 1, "R2");
        // R3: arrival mask
        lk(5, 2, 2, "R3");
        lk(5, 2, 0, "R3");
        // R7: miss
        lk(12, 12, 1, "R7");

        // entry 1: whole grid, all ports, output port 1
        region(1, 0, 15, 0, 15, 5'b11111, 5'b00010);
        wr(1, 6, 1, "R9");
        lk(5, 2, 1, "R5");
        lk(9, 9, 4, "R5");
        // R10: out-of-range arrival port
        lk(5, 2, 5, "R10");
        lk(5, 2, 15, "R10");
        // R6: local node
        lk(LX, LY, 1, "R6");
        lk(LX, LY, 7, "R6");
        // R9: reserved field changes nothing
        wr(1, 7, 0, "R9");
        lk(9, 9, 4, "R9");
        // R4: disable entry 1 while its other fields stay
        wr(1, 6, 0, "R4");
        lk(9, 9, 4, "R4");
        lk(5, 2, 1, "R4");

        // R8: back-to-back lookups then gap
        lk(4, 1, 1, "R8");
        lk(4, 1, 2, "R8");
        step(1'b0, 0, 0, 0, 1'b0, 4, 1, 1, "R8");

        // sweep: more overlapping entries, all coordinates and ports
        region(2, 0, 7, 8, 15, 5'b01100, 5'b01000);
        wr(2, 6, 1, "R9");
        region(7, 3, 10, 2, 9, 5'b10001, 5'b10000);
        wr(7, 6, 1, "R9");
        wr(1, 6, 1, "R9");
        wr(1, 0, 8, "R9");
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int p = 0; p < 6; p++) begin
                    lk(x, y, p, "R5");
                end
            end
        end
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "R8");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule